// File: doc/BRIEF.md
# Byte-Lane Realignment Buffer

This block sits between a read port and a write port and moves burst data when the source and the destination start at different byte positions inside a bus word. A read rotator turns each incoming beat so that the source bytes land in their stream positions. The bytes are then held in a buffer built from one small FIFO per byte lane. A write rotator turns the buffered bytes to the destination byte position and drives write data together with a byte strobe.

Each side frames its own beats. The read port marks its first and last beat. The write-side controller marks the first and last write beat. Plain control pins give the source and destination start offsets and the tails, held steady for the whole burst. The tail is the number of unused top lanes in the last beat.

Both data interfaces are valid/ready. A read beat is taken on a rising edge where `rd_valid_i` and `rd_ready_o` are both high. `rd_ready_o` falls as soon as any lane the current beat must fill is full. A write beat is taken where `wr_valid_o` and `wr_ready_i` are both high. `wr_valid_o` rises only when every lane that beat draws from holds a byte. While the beat waits for `wr_ready_i`, it stays offered and its data stays unchanged. A parameter selects a combined mode. In that mode a single rotation by the net shift (destination offset minus source offset) is applied before the buffer, and no rotator is placed after it.

Top module: `rlb_realign_buffer`

## Requirements
- R1: While reset is held and after it is released with nothing written, `busy_o` = 0 and `wr_valid_o` = 0. With `rd_first_i` = `rd_last_i` = 0, `rd_ready_o` = 1.
- R2: From a read beat, only stream bytes are stored. On the first beat (`rd_first_i` = 1) these are the lanes at index `src_off_i` or above. On the last beat (`rd_last_i` = 1) they are the lanes below LANES − `src_tail_i`. Other lanes may carry any value and never reach the write output.
- R3: Stream byte k (counted from 0 in source order) leaves on write beat ⌊(k + `dst_off_i`)/LANES⌋, at lane (k + `dst_off_i`) mod LANES. Lane i covers bits [8i+7:8i].
- R4: `wr_strb_o` bit d is 1 exactly for the lanes the beat carries. On the first write beat these are lanes d ≥ `dst_off_i`. On the last write beat they are lanes d < LANES − `dst_tail_i`. On all other beats every lane is set.
- R5: With MASK_EN = 1, every byte lane whose strobe bit is 0 drives 0x00 on `wr_data_o`.
- R6: `wr_valid_o` is 1 only when every lane the beat needs holds data. While `wr_ready_i` is low and the framing and control pins are unchanged, an offered beat stays offered.
- R7: `rd_ready_o` is 0 whenever any lane the incoming beat would fill is full. With the write side stalled, exactly DEPTH full-width aligned beats are accepted before `rd_ready_o` drops.
- R8: In combined mode (MODE = ROT_COMBINED), the write-side results of R3, R4 and R5 are the same as in split mode.
- R9: With DEPTH = 3, `rd_valid_i` held high and `wr_ready_i` held high, a misaligned burst (`src_off_i` ≠ `dst_off_i`) never sees `rd_ready_o` low.
- R10: `busy_o` is 1 whenever any lane FIFO holds a byte. It returns to 0 once a burst has been fully written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_off_i | input | $clog2(DATA_W/8) | Source byte offset in the first read beat |
| src_tail_i | input | $clog2(DATA_W/8) | Unused top lanes in the last read beat |
| dst_off_i | input | $clog2(DATA_W/8) | Destination byte offset in the first write beat |
| dst_tail_i | input | $clog2(DATA_W/8) | Unused top lanes in the last write beat |
| rd_valid_i | input | 1 | Read beat offered |
| rd_ready_o | output | 1 | Read beat can be taken |
| rd_first_i | input | 1 | Read beat is the first of its burst |
| rd_last_i | input | 1 | Read beat is the last of its burst |
| rd_data_i | input | DATA_W | Read beat data |
| wr_valid_o | output | 1 | Write beat offered |
| wr_ready_i | input | 1 | Write beat taken |
| wr_first_i | input | 1 | Write beat is the first of its burst |
| wr_last_i | input | 1 | Write beat is the last of its burst |
| wr_data_o | output | DATA_W | Write beat data |
| wr_strb_o | output | DATA_W/8 | Write byte strobe |
| busy_o | output | 1 | Some lane FIFO holds data |

## Verification
`rd_ready_o`, `wr_strb_o` and the masking are combinational, so they are due in the same cycle as the framing inputs they depend on. A write beat can appear one cycle after the read beat that completes its last needed lane is taken, because the lane FIFOs are the only register on the path. `busy_o` rises one cycle after the first push and falls one cycle after the final pop. The bench changes inputs on the falling edge and samples 1 ns later, so each result is read before the next rising edge. Whenever a handshake is not yet ready, the bench waits edge by edge rather than assuming a fixed latency.

// File: rtl/rlb_pkg.sv
package rlb_pkg;
  typedef enum logic {
    ROT_SPLIT    = 1'b0,
    ROT_COMBINED = 1'b1
  } rot_mode_e;
endpackage

// File: rtl/rlb_lane_window.sv
module rlb_lane_window #(
  parameter int LANES = 4,
  localparam int OW = $clog2(LANES)
) (
  input  logic [OW-1:0]    off_i,
  input  logic [OW-1:0]    tail_i,
  input  logic             first_i,
  input  logic             last_i,
  output logic [LANES-1:0] win_o
);
  // lanes carried by a beat: above the start offset on the first beat,
  // below the tail on the last beat
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      win_o[i] = (!first_i || (i >= int'(off_i))) &&
                 (!last_i  || (i < (LANES - int'(tail_i))));
    end
  end
endmodule

// File: rtl/rlb_rotator.sv
module rlb_rotator #(
  parameter int LANES = 4,
  parameter int W     = 8,
  localparam int OW = $clog2(LANES)
) (
  input  logic [LANES*W-1:0] din_i,
  input  logic [OW-1:0]      amt_i,
  output logic [LANES*W-1:0] dout_o
);
  // output lane j takes input lane (j + amt) mod LANES
  always_comb begin
    for (int j = 0; j < LANES; j++) begin
      dout_o[j*W +: W] = din_i[((j + int'(amt_i)) % LANES)*W +: W];
    end
  end
endmodule

// File: rtl/rlb_lane_fifo.sv
module rlb_lane_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 3,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         empty_o,
  output logic         full_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rp, wp;
  logic [CW-1:0] cnt;

  assign empty_o = (cnt == '0);
  assign full_o  = (cnt == CW'(DEPTH));
  assign dout_o  = mem[rp];

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wp] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rp  <= '0;
      wp  <= '0;
      cnt <= '0;
    end else begin
      if (push_i) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop_i)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(push_i) - CW'(pop_i);
    end
  end

  // R7: the read side never pushes into a full lane
  p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  // R6: the write side never pops an empty lane
  p_no_underflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/rlb_realign_buffer.sv
module rlb_realign_buffer
  import rlb_pkg::*;
#(
  parameter int        DATA_W  = 32,
  parameter int        DEPTH   = 3,
  parameter rot_mode_e MODE    = ROT_SPLIT,
  parameter bit        MASK_EN = 1'b1,
  localparam int LANES = DATA_W / 8,
  localparam int OW    = $clog2(LANES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OW-1:0]     src_off_i,
  input  logic [OW-1:0]     src_tail_i,
  input  logic [OW-1:0]     dst_off_i,
  input  logic [OW-1:0]     dst_tail_i,
  input  logic              rd_valid_i,
  output logic              rd_ready_o,
  input  logic              rd_first_i,
  input  logic              rd_last_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  input  logic              wr_first_i,
  input  logic              wr_last_i,
  output logic [DATA_W-1:0] wr_data_o,
  output logic [LANES-1:0]  wr_strb_o,
  output logic              busy_o
);
  logic [OW-1:0]     rd_amt;
  logic [LANES-1:0]  src_win, buf_win, dst_win, need;
  logic [LANES-1:0]  full, empty, push, pop;
  logic [DATA_W-1:0] buf_in, head, out_rot;
  logic [DATA_W-1:0] unstrb_bits;

  // read side: which source lanes carry stream bytes
  rlb_lane_window #(.LANES(LANES)) u_src_win (
    .off_i(src_off_i), .tail_i(src_tail_i),
    .first_i(rd_first_i), .last_i(rd_last_i), .win_o(src_win)
  );

  // write side: which destination lanes this beat carries
  rlb_lane_window #(.LANES(LANES)) u_dst_win (
    .off_i(dst_off_i), .tail_i(dst_tail_i),
    .first_i(wr_first_i), .last_i(wr_last_i), .win_o(dst_win)
  );

  if (MODE == ROT_COMBINED) begin : g_comb
    // one rotation by the net shift; buffer lanes equal destination lanes
    assign rd_amt  = src_off_i - dst_off_i;
    assign need    = dst_win;
    assign out_rot = head;
  end else begin : g_split
    logic [OW-1:0] neg_dst;
    assign rd_amt  = src_off_i;
    assign neg_dst = OW'(0) - dst_off_i;
    rlb_rotator #(.LANES(LANES), .W(1)) u_need_rot (
      .din_i(dst_win), .amt_i(dst_off_i), .dout_o(need)
    );
    rlb_rotator #(.LANES(LANES), .W(8)) u_wr_rot (
      .din_i(head), .amt_i(neg_dst), .dout_o(out_rot)
    );
  end

  rlb_rotator #(.LANES(LANES), .W(8)) u_rd_rot (
    .din_i(rd_data_i), .amt_i(rd_amt), .dout_o(buf_in)
  );
  rlb_rotator #(.LANES(LANES), .W(1)) u_rd_win_rot (
    .din_i(src_win), .amt_i(rd_amt), .dout_o(buf_win)
  );

  assign rd_ready_o = ~|(buf_win & full);
  assign push       = buf_win & {LANES{rd_valid_i & rd_ready_o}};

  assign wr_valid_o = ~|(need & empty);
  assign pop        = need & {LANES{wr_valid_o & wr_ready_i}};

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    rlb_lane_fifo #(.W(8), .DEPTH(DEPTH)) u_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (push[j]),
      .din_i   (buf_in[j*8 +: 8]),
      .pop_i   (pop[j]),
      .dout_o  (head[j*8 +: 8]),
      .empty_o (empty[j]),
      .full_o  (full[j])
    );
  end

  always_comb begin
    for (int d = 0; d < LANES; d++) begin
      wr_data_o[d*8 +: 8]   = (MASK_EN && !dst_win[d]) ? 8'h00 : out_rot[d*8 +: 8];
      unstrb_bits[d*8 +: 8] = {8{~wr_strb_o[d]}};
    end
  end

  assign wr_strb_o = dst_win;
  assign busy_o    = ~&empty;

  // R6: an offered beat is not withdrawn while the sink stalls
  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && !wr_ready_i) |=>
      (wr_valid_o || !$stable({wr_first_i, wr_last_i, dst_off_i, dst_tail_i})));

  // R10: nothing can be offered from an empty buffer
  p_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !(wr_valid_o && wr_ready_i && (wr_strb_o != '0)));

  if (MASK_EN) begin : g_mask_chk
    // R5: unstrobed lanes are quiet
    p_mask_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_valid_o |-> ((wr_data_o & unstrb_bits) == '0));
  end
endmodule

// File: tb/sim_rlb_realign_buffer.sv
module sim_rlb_realign_buffer;
  import rlb_pkg::*;

  localparam int L  = 4;
  localparam int DW = 32;
  localparam int DP = 3;
  localparam int NV = 8;
  // fields: [15:14] source offset, [13:12] destination offset, [11:0] bytes
  localparam logic [15:0] VTAB [NV] = '{
    {2'd0, 2'd0, 12'd16}, {2'd1, 2'd0, 12'd10}, {2'd0, 2'd3, 12'd9},
    {2'd3, 2'd1, 12'd5},  {2'd2, 2'd2, 12'd2},  {2'd3, 2'd0, 12'd1},
    {2'd1, 2'd2, 12'd13}, {2'd2, 2'd3, 12'd20}
  };

  logic clk = 1'b0, rst_n = 1'b0, sel = 1'b0;
  logic [1:0] src_off = '0, src_tail = '0, dst_off = '0, dst_tail = '0;
  logic rd_valid = 1'b0, rd_first = 1'b0, rd_last = 1'b0;
  logic [DW-1:0] rd_data = '0;
  logic wr_ready = 1'b0, wr_first = 1'b0, wr_last = 1'b0;

  logic rr0, rr1, wv0, wv1, by0, by1;
  logic [DW-1:0] wd0, wd1;
  logic [L-1:0] ws0, ws1;

  int total = 0, bad = 0, cyc = 0, rd_acc = 0, stalls = 0;

  always #10 clk = ~clk;

  rlb_realign_buffer #(.DATA_W(DW), .DEPTH(DP), .MODE(ROT_SPLIT)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .src_off_i(src_off), .src_tail_i(src_tail),
    .dst_off_i(dst_off), .dst_tail_i(dst_tail),
    .rd_valid_i(rd_valid & ~sel), .rd_ready_o(rr0),
    .rd_first_i(rd_first), .rd_last_i(rd_last), .rd_data_i(rd_data),
    .wr_valid_o(wv0), .wr_ready_i(wr_ready & ~sel),
    .wr_first_i(wr_first), .wr_last_i(wr_last),
    .wr_data_o(wd0), .wr_strb_o(ws0), .busy_o(by0)
  );

  rlb_realign_buffer #(.DATA_W(DW), .DEPTH(DP), .MODE(ROT_COMBINED)) u1 (
    .clk_i(clk), .rst_ni(rst_n),
    .src_off_i(src_off), .src_tail_i(src_tail),
    .dst_off_i(dst_off), .dst_tail_i(dst_tail),
    .rd_valid_i(rd_valid & sel), .rd_ready_o(rr1),
    .rd_first_i(rd_first), .rd_last_i(rd_last), .rd_data_i(rd_data),
    .wr_valid_o(wv1), .wr_ready_i(wr_ready & sel),
    .wr_first_i(wr_first), .wr_last_i(wr_last),
    .wr_data_o(wd1), .wr_strb_o(ws1), .busy_o(by1)
  );

  wire          rr_m = sel ? rr1 : rr0;
  wire          wv_m = sel ? wv1 : wv0;
  wire          by_m = sel ? by1 : by0;
  wire [DW-1:0] wd_m = sel ? wd1 : wd0;
  wire [L-1:0]  ws_m = sel ? ws1 : ws0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] bval(input int seed, input int k);
    return 8'h80 | 8'((seed + 5 * k) & 8'h7f);
  endfunction

  task automatic set_burst(input bit m, input int so, input int dof, input int n);
    @(negedge clk);
    sel      = m;
    src_off  = 2'(so);
    dst_off  = 2'(dof);
    src_tail = 2'((L - ((so + n) % L)) % L);
    dst_tail = 2'((L - ((dof + n) % L)) % L);
  endtask

  task automatic run_read(input int so, input int n, input int seed, input int b0);
    int nb = (so + n + L - 1) / L;
    for (int b = b0; b < nb; b++) begin
      @(negedge clk);
      rd_valid = 1'b1;
      rd_first = (b == 0);
      rd_last  = (b == nb - 1);
      for (int i = 0; i < L; i++) begin
        int k = b * L + i - so;
        rd_data[i*8 +: 8] = (k >= 0 && k < n) ? bval(seed, k) : 8'hEE;
      end
      forever begin
        #1;
        if (rr_m) begin
          @(posedge clk);
          rd_acc++;
          break;
        end
        stalls++;
        @(negedge clk);
      end
    end
    @(negedge clk);
    rd_valid = 1'b0;
  endtask

  task automatic run_write(input int dof, input int n, input int seed, input int hold,
                           input string tag);
    int nb = (dof + n + L - 1) / L;
    logic [DW-1:0] ed;
    logic [L-1:0]  es;
    wr_ready = 1'b0;
    wr_first = 1'b1;
    wr_last  = (nb == 1);
    repeat (hold) @(negedge clk);
    for (int b = 0; b < nb; b++) begin
      @(negedge clk);
      wr_ready = 1'b1;
      wr_first = (b == 0);
      wr_last  = (b == nb - 1);
      for (int d = 0; d < L; d++) begin
        int k = b * L + d - dof;
        es[d]        = (k >= 0 && k < n);
        ed[d*8 +: 8] = es[d] ? bval(seed, k) : 8'h00;
      end
      forever begin
        #1;
        if (wv_m) begin
          chk(wd_m == ed && ws_m == es, tag, {wd_m, 28'd0, ws_m}, {ed, 28'd0, es});
          @(posedge clk);
          break;
        end
        @(negedge clk);
      end
    end
    @(negedge clk);
    wr_ready = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=<100000", cyc);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1 during reset
    chk(!by0 && !wv0 && rr0 && !by1 && !wv1 && rr1, "R1 in reset",
        {by0, wv0, rr0, by1, wv1, rr1}, 6'b001001);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(!by0 && !wv0 && rr0 && !by1 && !wv1 && rr1, "R1 after reset",
        {by0, wv0, rr0, by1, wv1, rr1}, 6'b001001);

    // vector table: split mode checks R2 R3 R4 R5, combined mode R8
    for (int m = 0; m < 2; m++) begin
      for (int v = 0; v < NV; v++) begin
        int so   = int'(VTAB[v][15:14]);
        int dof  = int'(VTAB[v][13:12]);
        int n    = int'(VTAB[v][11:0]);
        int seed = 17 * v + 3 * m + 1;
        set_burst(m[0], so, dof, n);
        fork
          run_read(so, n, seed, 0);
          run_write(dof, n, seed, 0, m == 0 ? "R2 R3 R4 R5 split" : "R8 combined");
        join
        @(negedge clk);
        #1;
        chk(!by_m, "R10 idle after burst", {63'd0, by_m}, 64'd0);
      end
    end

    // R7: write stalled, DEPTH aligned beats accepted then back-pressure
    set_burst(1'b0, 0, 0, 24);
    rd_acc = 0;
    fork
      run_read(0, 24, 91, 0);
      run_write(0, 24, 91, 8, "R7 drain");
      begin
        repeat (6) @(negedge clk);
        #2;
        chk(!rr_m && rd_acc == DP, "R7 back-pressure",
            {31'd0, rr_m, rd_acc}, {32'd0, DP});
        chk(by_m, "R10 busy while held", {63'd0, by_m}, 64'd1);
        chk(wv_m, "R6 beat offered while sink stalls", {63'd0, wv_m}, 64'd1);
      end
    join

    // R6: first write beat waits for a lane filled only by the second read beat
    set_burst(1'b0, 1, 0, 8);
    @(negedge clk);
    rd_valid = 1'b1;
    rd_first = 1'b1;
    rd_last  = 1'b0;
    for (int i = 0; i < L; i++) rd_data[i*8 +: 8] = (i >= 1) ? bval(55, i - 1) : 8'hEE;
    @(posedge clk);
    @(negedge clk);
    rd_valid = 1'b0;
    wr_first = 1'b1;
    wr_last  = 1'b0;
    #1;
    chk(!wv_m, "R6 wait for missing lane", {63'd0, wv_m}, 64'd0);
    chk(by_m, "R10 busy after first push", {63'd0, by_m}, 64'd1);
    fork
      run_read(1, 8, 55, 1);
      run_write(0, 8, 55, 0, "R6 completed beat");
    join

    // R9: continuous misaligned burst at depth 3 never back-pressures
    set_burst(1'b0, 0, 1, 40);
    stalls = 0;
    fork
      run_read(0, 40, 123, 0);
      run_write(1, 40, 123, 0, "R9 data");
    join
    chk(stalls == 0, "R9 no read stall", 64'(stalls), 64'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule